// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the eight-bit status byte of a serial NOR flash together with the write-enable latch that gates every change to the memory array. An upstream parser has already shifted in the serial stream and decoded each opcode into one single-cycle strobe. These strobes are enable, disable, status write, page program, dual-input page program, sector erase, block erase, chip erase, ID-area program, ID-area lockout and status read. A single completion pulse comes back from the internal program/erase engine.

The block decides whether each write-class command is accepted or refused. An accepted program or erase raises the busy flag until the engine reports completion. The ID-area lock bit is sticky. The block drives it out so that it can be stored, and the stored value returns on an input at power-up.

Status reads leave through a valid/ready channel that holds one byte. The byte is the status value captured in the cycle the read strobe arrived. While `rd_valid_o` is high and `rd_ready_i` is low, the byte and the valid flag hold, and any further read strobes are dropped. A transfer completes on a cycle where both are high. In that same cycle a new read strobe can load the next byte.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte is arranged as follows: bit 0 busy, bit 1 write-enable latch, bits 5..2 protection level (lowest level bit at bit 2), bit 6 ID-area lock, bit 7 protection freeze. `busy_o` always equals bit 0.
- R2: After reset, busy=0, latch=0, protection=1111 and freeze=0, so the byte reads 0x3C. The lock bit equals `lock_persist_i`.
- R3: When the block is idle, an enable strobe sets the latch on the next clock and a disable strobe clears it on the next clock.
- R4: A status write with the latch set has the following effects on the next clock. Freeze takes data bit 7, and protection takes data bits 5..2 unless freeze was already 1. Data bits 0, 1 and 6 have no effect. The latch clears, and `grant_o` pulses for one cycle.
- R5: While freeze is 1, a status write leaves the protection bits unchanged. Freeze itself stays writable.
- R6: A status write, program, erase, ID program or ID lockout that arrives with the latch clear pulses `reject_o` on the next clock and changes no state.
- R7: An accepted program, erase, ID program or lockout pulses `grant_o` and sets busy on the next clock, and the latch stays set. A completion pulse while busy clears both busy and the latch on the next clock. A completion pulse while idle has no effect.
- R8: While busy, every strobe except status read is ignored: no grant, no reject and no change to the latch, freeze or protection bits.
- R9: Completion of a lockout sets the lock bit and `lock_persist_o` on the next clock. Both stay set until reset.
- R10: A status read strobe, accepted even while busy, makes `rd_valid_o` high on the next clock. `rd_data_o` then holds the status byte of the strobe cycle.
- R11: While `rd_valid_o` is high and `rd_ready_i` is low, valid and data hold and new read strobes are dropped. After a transfer, valid falls unless a new strobe was accepted in that cycle.
- R12: Simultaneous strobes resolve in this fixed order: disable, enable, status write, page program, dual page program, sector erase, block erase, chip erase, ID program, lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| lock_persist_i | input | 1 | Stored lock flag returned at power-up |
| wr_disable_i | input | 1 | Write-disable strobe |
| wr_enable_i | input | 1 | Write-enable strobe |
| set_status_i | input | 1 | Status-write strobe |
| set_status_data_i | input | PROT_W+4 | Status-write data byte |
| page_prog_i | input | 1 | Page program strobe |
| dual_prog_i | input | 1 | Dual-input page program strobe |
| sector_erase_i | input | 1 | Sector erase strobe |
| block_erase_i | input | 1 | Block erase strobe |
| chip_erase_i | input | 1 | Chip erase strobe |
| id_prog_i | input | 1 | ID-area program strobe |
| id_lock_i | input | 1 | ID-area lockout strobe |
| status_rd_i | input | 1 | Status read strobe |
| engine_done_i | input | 1 | Program/erase engine completion pulse |
| rd_ready_i | input | 1 | Read channel ready |
| status_o | output | PROT_W+4 | Live status byte |
| busy_o | output | 1 | Busy flag |
| grant_o | output | 1 | Write command accepted pulse |
| reject_o | output | 1 | Write command refused pulse |
| lock_persist_o | output | 1 | Lock flag to be stored |
| rd_valid_o | output | 1 | Read channel valid |
| rd_data_o | output | PROT_W+4 | Read channel byte |

## Verification
Every result of this block is due exactly one clock after the strobe, completion pulse or handshake that causes it. This holds for the latch, the protection fields, busy, grant, reject, the lock bit and the read channel. The one exception is the lock bit's power-up value, which follows `lock_persist_i` with no delay. The bench drives stimulus on falling edges and updates its reference model on the rising edge that registers the stimulus. It then compares every output on the following falling edge, so each comparison lands in the first cycle the result is due. The directed checks are placed the same way, one full cycle after each pulse.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int NUM_STROBES = 10;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_WDIS,
    OP_WEN,
    OP_STW,
    OP_PAGE,
    OP_DPAGE,
    OP_SECT,
    OP_BLOCK,
    OP_CHIP,
    OP_IDPROG,
    OP_IDLOCK
  } fsc_op_e;

  // strobe index -> operation; index order is the priority order (0 wins)
  function automatic fsc_op_e strobe_op(input int idx);
    case (idx)
      0: return OP_WDIS;
      1: return OP_WEN;
      2: return OP_STW;
      3: return OP_PAGE;
      4: return OP_DPAGE;
      5: return OP_SECT;
      6: return OP_BLOCK;
      7: return OP_CHIP;
      8: return OP_IDPROG;
      9: return OP_IDLOCK;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic uses_engine(input fsc_op_e op);
    return op inside {OP_PAGE, OP_DPAGE, OP_SECT, OP_BLOCK, OP_CHIP, OP_IDPROG, OP_IDLOCK};
  endfunction

  function automatic logic needs_wel(input fsc_op_e op);
    return (op == OP_STW) || uses_engine(op);
  endfunction

endpackage

// File: rtl/fsc_cmd_sel.sv
module fsc_cmd_sel
  import fsc_pkg::*;
(
  input  logic [NUM_STROBES-1:0] strobe_i,
  input  logic                   busy_i,
  output fsc_op_e                op_o
);

  // lowest strobe index wins; nothing passes while the engine runs
  always_comb begin
    op_o = OP_NONE;
    if (!busy_i) begin
      for (int i = NUM_STROBES - 1; i >= 0; i--) begin
        if (strobe_i[i]) op_o = strobe_op(i);
      end
    end
  end

endmodule

// File: rtl/fsc_wel.sv
module fsc_wel
  import fsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fsc_op_e op_i,
  input  logic    done_i,
  output logic    wel_o,
  output logic    grant_o,
  output logic    reject_o
);

  logic wel_q, grant_q, rej_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      grant_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      rej_q   <= 1'b0;
      if (done_i) begin
        wel_q <= 1'b0;
      end else begin
        case (op_i)
          OP_WEN:  wel_q <= 1'b1;
          OP_WDIS: wel_q <= 1'b0;
          default: begin
            if (needs_wel(op_i)) begin
              if (wel_q) begin
                grant_q <= 1'b1;
                if (op_i == OP_STW) wel_q <= 1'b0;
              end else begin
                rej_q <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign wel_o    = wel_q;
  assign grant_o  = grant_q;
  assign reject_o = rej_q;

  assert_refused_keeps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (needs_wel(op_i) && !wel_o && !done_i) |=> (reject_o && !grant_o && !wel_o));

  assert_enable_sets_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_WEN && !done_i) |=> wel_o);

  assert_completion_clears_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !wel_o);

endmodule

// File: rtl/fsc_prot.sv
module fsc_prot #(
  parameter int PROT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [PROT_W-1:0] prot_d_i,
  input  logic              freeze_d_i,
  output logic [PROT_W-1:0] prot_o,
  output logic              freeze_o
);

  logic [PROT_W-1:0] prot_q;
  logic              frz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '1;
      frz_q  <= 1'b0;
    end else if (wr_i) begin
      frz_q <= freeze_d_i;
      if (!frz_q) prot_q <= prot_d_i;
    end
  end

  assign prot_o   = prot_q;
  assign freeze_o = frz_q;

  assert_frozen_prot_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |=> $stable(prot_o));

  assert_idle_prot_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(prot_o) && $stable(freeze_o)));

endmodule

// File: rtl/fsc_engine.sv
module fsc_engine (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic lock_op_i,
  input  logic done_i,
  output logic busy_o,
  output logic lock_o
);

  logic busy_q, lock_pend_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      lock_pend_q <= 1'b0;
      lock_q      <= 1'b0;
    end else if (busy_q) begin
      if (done_i) begin
        busy_q <= 1'b0;
        if (lock_pend_q) lock_q <= 1'b1;
      end
    end else if (start_i) begin
      busy_q      <= 1'b1;
      lock_pend_q <= lock_op_i;
    end
  end

  assign busy_o = busy_q;
  assign lock_o = lock_q;

  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_done_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i) |=> !busy_o);

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o);

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int PROT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_persist_i,
  input  logic              wr_disable_i,
  input  logic              wr_enable_i,
  input  logic              set_status_i,
  input  logic [PROT_W+3:0] set_status_data_i,
  input  logic              page_prog_i,
  input  logic              dual_prog_i,
  input  logic              sector_erase_i,
  input  logic              block_erase_i,
  input  logic              chip_erase_i,
  input  logic              id_prog_i,
  input  logic              id_lock_i,
  input  logic              status_rd_i,
  input  logic              engine_done_i,
  input  logic              rd_ready_i,
  output logic [PROT_W+3:0] status_o,
  output logic              busy_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              lock_persist_o,
  output logic              rd_valid_o,
  output logic [PROT_W+3:0] rd_data_o
);

  localparam int SR_W    = PROT_W + 4;
  localparam int PROT_LO = 2;
  localparam int PROT_HI = PROT_LO + PROT_W - 1;
  localparam int LOCK_B  = PROT_HI + 1;
  localparam int FRZ_B   = LOCK_B + 1;

  logic [NUM_STROBES-1:0] strobes;
  fsc_op_e                op;
  logic                   busy, wel, lock_seen, freeze;
  logic [PROT_W-1:0]      prot;
  logic                   stw_go, eng_go, done_ok, id_lock;
  logic [SR_W-1:0]        status;
  logic                   rv_q;
  logic [SR_W-1:0]        rd_q;
  logic                   data_unused;

  assign strobes = {id_lock_i, id_prog_i, chip_erase_i, block_erase_i, sector_erase_i,
                    dual_prog_i, page_prog_i, set_status_i, wr_enable_i, wr_disable_i};

  fsc_cmd_sel u_sel (
    .strobe_i (strobes),
    .busy_i   (busy),
    .op_o     (op)
  );

  assign done_ok = busy && engine_done_i;
  assign stw_go  = (op == OP_STW) && wel;
  assign eng_go  = uses_engine(op) && wel;

  fsc_wel u_wel (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .done_i   (done_ok),
    .wel_o    (wel),
    .grant_o  (grant_o),
    .reject_o (reject_o)
  );

  fsc_prot #(.PROT_W(PROT_W)) u_prot (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (stw_go),
    .prot_d_i   (set_status_data_i[PROT_HI:PROT_LO]),
    .freeze_d_i (set_status_data_i[FRZ_B]),
    .prot_o     (prot),
    .freeze_o   (freeze)
  );

  fsc_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (eng_go),
    .lock_op_i (op == OP_IDLOCK),
    .done_i    (engine_done_i),
    .busy_o    (busy),
    .lock_o    (lock_seen)
  );

  // bits that a status write never touches
  assign data_unused = ^{set_status_data_i[1:0], set_status_data_i[LOCK_B]};

  assign id_lock = lock_seen | lock_persist_i;
  assign status  = {freeze, id_lock, prot, wel, busy};

  // one-entry read channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else if (!rv_q || rd_ready_i) begin
      rv_q <= status_rd_i;
      if (status_rd_i) rd_q <= status;
    end
  end

  assign status_o       = status;
  assign busy_o         = busy;
  assign lock_persist_o = id_lock;
  assign rd_valid_o     = rv_q;
  assign rd_data_o      = rd_q;

  assert_read_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_read_issues_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd_i && (!rd_valid_o || rd_ready_i)) |=> rd_valid_o);

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !engine_done_i) |=>
      (!grant_o && !reject_o && $stable({freeze, prot, wel})));

  assert_busy_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == status_o[0]);

endmodule

// File: tb/test_flash_status_ctrl.sv
`timescale 1ns/1ps
module test_flash_status_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       persist = 1'b0;
  logic [9:0] strb = '0;
  logic [7:0] sdata = '0;
  logic       rdsr = 1'b0;
  logic       done = 1'b0;
  logic       rd_ready = 1'b1;
  logic       cmp_en = 1'b0;

  logic [7:0] status_o, rd_data_o;
  logic       busy_o, grant_o, reject_o, lock_persist_o, rd_valid_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flash_status_ctrl i_flash_status_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .lock_persist_i    (persist),
    .wr_disable_i      (strb[0]),
    .wr_enable_i       (strb[1]),
    .set_status_i      (strb[2]),
    .set_status_data_i (sdata),
    .page_prog_i       (strb[3]),
    .dual_prog_i       (strb[4]),
    .sector_erase_i    (strb[5]),
    .block_erase_i     (strb[6]),
    .chip_erase_i      (strb[7]),
    .id_prog_i         (strb[8]),
    .id_lock_i         (strb[9]),
    .status_rd_i       (rdsr),
    .engine_done_i     (done),
    .rd_ready_i        (rd_ready),
    .status_o          (status_o),
    .busy_o            (busy_o),
    .grant_o           (grant_o),
    .reject_o          (reject_o),
    .lock_persist_o    (lock_persist_o),
    .rd_valid_o        (rd_valid_o),
    .rd_data_o         (rd_data_o)
  );

  // ---------------- reference model ----------------
  logic       m_busy, m_wel, m_frz, m_sec, m_lockop, m_grant, m_rej, m_rv;
  logic [3:0] m_prot;
  logic [7:0] m_rd, m_snap;

  function automatic logic [7:0] m_status();
    return {m_frz, m_sec | persist, m_prot, m_wel, m_busy};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wel = 0; m_frz = 0; m_sec = 0; m_lockop = 0;
      m_grant = 0; m_rej = 0; m_rv = 0; m_prot = 4'hF; m_rd = 0;
    end else begin
      m_snap  = m_status();
      m_grant = 0;
      m_rej   = 0;
      if (!m_rv || rd_ready) begin
        m_rv = rdsr;
        if (rdsr) m_rd = m_snap;
      end
      if (m_busy) begin
        if (done) begin
          m_busy = 0;
          m_wel  = 0;
          if (m_lockop) m_sec = 1;
        end
      end else if (strb[0]) m_wel = 0;
      else if (strb[1]) m_wel = 1;
      else if (strb[2]) begin
        if (m_wel) begin
          m_grant = 1;
          m_wel   = 0;
          if (!m_frz) m_prot = sdata[5:2];
          m_frz = sdata[7];
        end else m_rej = 1;
      end else if (|strb[9:3]) begin
        if (m_wel) begin
          m_grant  = 1;
          m_busy   = 1;
          m_lockop = (strb[8:3] == 6'b0);
        end else m_rej = 1;
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk({7'b0, status_o[0]}, {7'b0, m_busy}, "R7 busy bit");
      chk({7'b0, busy_o}, {7'b0, m_busy}, "R1 busy pin");
      chk({7'b0, status_o[1]}, {7'b0, m_wel}, "R3 latch bit");
      chk({4'b0, status_o[5:2]}, {4'b0, m_prot}, "R4 protection bits");
      chk({7'b0, status_o[7]}, {7'b0, m_frz}, "R5 freeze bit");
      chk({7'b0, status_o[6]}, {7'b0, m_sec | persist}, "R9 lock bit");
      chk({7'b0, lock_persist_o}, {7'b0, m_sec | persist}, "R9 lock output");
      chk({7'b0, grant_o}, {7'b0, m_grant}, "R4 grant");
      chk({7'b0, reject_o}, {7'b0, m_rej}, "R6 reject");
      chk({7'b0, rd_valid_o}, {7'b0, m_rv}, "R11 read valid");
      if (m_rv) chk(rd_data_o, m_rd, "R10 read data");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_mask(input logic [9:0] mask, input logic [7:0] d);
    strb = mask; sdata = d;
    @(negedge clk);
    strb = '0; sdata = '0;
  endtask

  task automatic pulse(input int idx, input logic [7:0] d);
    logic [9:0] m;
    m = '0;
    m[idx] = 1'b1;
    pulse_mask(m, d);
  endtask

  task automatic done_pulse();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic read_pulse();
    rdsr = 1'b1;
    @(negedge clk);
    rdsr = 1'b0;
  endtask

  task automatic do_reset(input logic p);
    cmp_en = 1'b0;
    rst_n  = 1'b0;
    persist = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic saved;
    do_reset(1'b0);
    chk(status_o, 8'h3C, "R2 reset status");
    chk({7'b0, busy_o}, 8'h00, "R1 busy pin after reset");

    // refusals with the latch clear
    pulse(2, 8'h00);
    chk({7'b0, reject_o}, 8'h01, "R6 status write refused");
    chk(status_o, 8'h3C, "R6 state unchanged after refused write");
    pulse(3, 8'h00);
    chk({7'b0, reject_o}, 8'h01, "R6 program refused");
    chk({7'b0, busy_o}, 8'h00, "R6 no busy after refusal");

    // latch set / clear / priority
    pulse(1, 8'h00);
    chk(status_o, 8'h3E, "R3 enable sets latch");
    pulse(0, 8'h00);
    chk(status_o, 8'h3C, "R3 disable clears latch");
    pulse_mask(10'b00_0000_0011, 8'h00);
    chk(status_o, 8'h3C, "R12 disable wins over enable");

    // status writes
    pulse(1, 8'h00);
    pulse(2, 8'h00);
    chk({7'b0, grant_o}, 8'h01, "R4 status write granted");
    chk(status_o, 8'h00, "R4 protection written, latch cleared");
    pulse(1, 8'h00);
    pulse(2, 8'hFF);
    chk(status_o, 8'hBC, "R4 bits 0,1,6 of data ignored");
    pulse(1, 8'h00);
    pulse(2, 8'h00);
    chk(status_o, 8'h3C, "R5 frozen protection kept, freeze cleared");
    pulse(1, 8'h00);
    pulse(2, 8'h04);
    chk(status_o, 8'h04, "R5 protection writable after unfreeze");

    // program / erase paths
    for (int idx = 3; idx <= 8; idx++) begin
      pulse(1, 8'h00);
      pulse(idx, 8'h00);
      chk({7'b0, grant_o}, 8'h01, "R7 engine op granted");
      chk(status_o, 8'h07, "R7 busy with latch held");
      pulse(0, 8'h00);
      pulse(2, 8'hFF);
      pulse(3, 8'h00);
      chk({6'b0, grant_o, reject_o}, 8'h00, "R8 no grant or reject while busy");
      chk(status_o, 8'h07, "R8 state kept while busy");
      read_pulse();
      chk({7'b0, rd_valid_o}, 8'h01, "R10 read honoured while busy");
      chk(rd_data_o, 8'h07, "R10 read byte while busy");
      done_pulse();
      chk(status_o, 8'h04, "R7 completion clears busy and latch");
      done_pulse();
      chk(status_o, 8'h04, "R7 completion while idle ignored");
    end

    // status write outranks program
    pulse(1, 8'h00);
    pulse_mask(10'b00_0000_1100, 8'h08);
    chk(status_o, 8'h08, "R12 status write wins over program");

    // lockout
    pulse(1, 8'h00);
    pulse(9, 8'h00);
    chk(status_o, 8'h0B, "R7 lockout busy");
    done_pulse();
    chk(status_o, 8'h48, "R9 lock bit set on lockout completion");
    chk({7'b0, lock_persist_o}, 8'h01, "R9 lock output set");
    pulse(1, 8'h00);
    pulse(2, 8'h00);
    chk(status_o, 8'h40, "R9 lock bit sticky");

    // power-up with stored lock
    saved = lock_persist_o;
    do_reset(saved);
    chk(status_o, 8'h7C, "R2 power-up lock follows stored flag");
    do_reset(1'b0);
    chk(status_o, 8'h3C, "R9 power-up lock clear when not stored");

    // back-pressure
    rd_ready = 1'b0;
    read_pulse();
    chk({7'b0, rd_valid_o}, 8'h01, "R11 valid raised");
    chk(rd_data_o, 8'h3C, "R10 snapshot byte");
    rdsr = 1'b1;
    pulse(1, 8'h00);
    rdsr = 1'b0;
    chk(rd_data_o, 8'h3C, "R11 held byte under back-pressure");
    repeat (2) @(negedge clk);
    chk({7'b0, rd_valid_o}, 8'h01, "R11 valid held");
    rd_ready = 1'b1;
    @(negedge clk);
    chk({7'b0, rd_valid_o}, 8'h00, "R11 valid falls after transfer");
    read_pulse();
    chk(rd_data_o, 8'h3E, "R10 fresh snapshot");
    @(negedge clk);

    summary();
    $finish;
  end

endmodule